// File: doc/BRIEF.md
# CPU Debug Control Port

This block is the register-level control point a debugger uses to steer one CPU core. A single command channel (valid/ready, with a write flag, an 8-bit address and a data word) reaches two locations. The control word holds four flags: a reset request, a halt request, a marker saying the halt came from a breakpoint, and a single-step enable. The second location reads back the most recent value the core wrote into its register file. A write to it hands an instruction word to the halted core.

Read responses come back as a one-cycle pulse on the cycle after the command is accepted. Writes produce no response. The command channel applies back-pressure in only one case: while an injected instruction has not yet been taken by the core, `cmd_ready` is low. A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. The requester must hold its command fields steady until that edge.

All flag state is cleared only by the block's own reset, `dbg_rst_n`. The reset request it drives toward the core and its peripherals therefore never clears the debug state that asked for it.

Top module: `dbg_ctl_port`

## Requirements
- R1: After `dbg_rst_n` is released, all four flags are 0, `core_halt`, `core_rst_req` and `inj_valid` are 0, `cmd_ready` is 1, and a read of the last-register-write location returns 0.
- R2: Each accepted read raises `rsp_valid` for exactly the next cycle. It carries data sampled at the accepting edge. An accepted write leaves `rsp_valid` low.
- R3: A read of address 0x00 returns the control word: bit 0 reset request, bit 1 halt request, bit 2 the live `core_busy` input, bit 3 halted-by-breakpoint, bit 4 step enable, and all other bits 0.
- R4: A write to 0x00 sets the reset request when data bit 16 is 1 and sets the halt request when data bit 17 is 1. A 0 in those bits leaves the flag unchanged.
- R5: A write to 0x00 clears the reset request when data bit 24 is 1. When bit 25 is 1 it clears both the halt request and the breakpoint marker. A clear beats a set of the same flag in the same write, and beats a breakpoint in the same cycle.
- R6: Every write to 0x00 loads the step enable from data bit 4.
- R7: A one-cycle pulse on `core_bkpt` sets both the halt request and the breakpoint marker.
- R8: With step enabled and halt low, one `core_issue` pulse sets the halt request on the following edge. With step disabled, issues leave halt low.
- R9: A read of 0x04 returns the data of the most recent cycle with `core_rf_we` high. Cycles with `core_rf_we` low do not change it.
- R10: A write to 0x04 drives `inj_valid` high with `inj_instr` equal to the written data from the next cycle. Both hold steady until an edge with `inj_ready` high. `cmd_ready` stays low over that whole interval.
- R11: `core_halt` and `core_rst_req` always equal the halt and reset flags as read at 0x00.
- R12: Reads of addresses other than 0x00 and 0x04 return 0. Writes to them change no flag and start no injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| dbg_rst_n | input | 1 | Active-low reset of the debug state only |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken (low while an injection is pending) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Byte address (0x00 control, 0x04 register/inject) |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rsp_data | output | 32 | Read data |
| core_busy | input | 1 | Core pipeline holds instructions |
| core_bkpt | input | 1 | Core hit a breakpoint (pulse) |
| core_issue | input | 1 | Core issued one instruction (pulse) |
| core_rf_we | input | 1 | Core writes its register file |
| core_rf_wdata | input | 32 | Data of that register-file write |
| core_halt | output | 1 | Halt request to the core |
| core_rst_req | output | 1 | Reset request to the core and peripherals |
| inj_valid | output | 1 | Injected instruction available |
| inj_instr | output | 32 | Injected instruction word |
| inj_ready | input | 1 | Core takes the injected instruction |

## Verification
The properties assume the requester keeps the command fields steady while `cmd_valid` waits on a low `cmd_ready`. They also assume `core_bkpt` and `core_issue` are treated as single-cycle events, so a step property can relate one issue to the halt that follows it. The bench drives every command only after it sees `cmd_ready` high and holds the fields for exactly the accepting edge. It pulses the core events for one cycle each. It raises `inj_ready` only while `inj_valid` is high. The flag sweep covers all 32 combinations of the set, clear and step bits from each of the four reset/halt starting states, with `core_busy` toggled alongside.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h00;
  localparam logic [7:0] ADDR_XFER = 8'h04;

  // Control word read layout
  localparam int unsigned RB_RST  = 0;
  localparam int unsigned RB_HALT = 1;
  localparam int unsigned RB_BUSY = 2;
  localparam int unsigned RB_BRK  = 3;
  localparam int unsigned RB_STEP = 4;

  // Control word write layout
  localparam int unsigned WB_STEP     = 4;
  localparam int unsigned WB_SET_RST  = 16;
  localparam int unsigned WB_SET_HALT = 17;
  localparam int unsigned WB_CLR_RST  = 24;
  localparam int unsigned WB_CLR_HALT = 25;

  typedef struct packed {
    logic rst;
    logic halt;
    logic brk;
    logic step;
  } dbg_flags_t;
endpackage

// File: rtl/dbg_flags.sv
module dbg_flags
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              bkpt,
  input  logic              issue,
  output dbg_flags_t        flags
);
  dbg_flags_t nxt;

  always_comb begin
    nxt = flags;
    // events from the core
    if (bkpt) begin
      nxt.halt = 1'b1;
      nxt.brk  = 1'b1;
    end
    if (flags.step && !flags.halt && issue) nxt.halt = 1'b1;
    // software write: set first, clear last so clear has priority
    if (wr_en) begin
      nxt.step = wdata[WB_STEP];
      if (wdata[WB_SET_RST])  nxt.rst  = 1'b1;
      if (wdata[WB_SET_HALT]) nxt.halt = 1'b1;
      if (wdata[WB_CLR_RST])  nxt.rst  = 1'b0;
      if (wdata[WB_CLR_HALT]) begin
        nxt.halt = 1'b0;
        nxt.brk  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end
endmodule

// File: rtl/dbg_inject.sv
module dbg_inject #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ldata,
  input  logic              inj_ready,
  output logic              inj_valid,
  output logic [DATA_W-1:0] inj_instr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_valid <= 1'b0;
      inj_instr <= '0;
    end else if (load) begin
      inj_valid <= 1'b1;
      inj_instr <= ldata;
    end else if (inj_valid && inj_ready) begin
      inj_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_readback.sv
module dbg_readback
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rf_we,
  input  logic [DATA_W-1:0] rf_wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] ctrl_word,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [DATA_W-1:0] rf_last;
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (rd_addr == ADDR_W'(ADDR_CTRL))      sel = ctrl_word;
    else if (rd_addr == ADDR_W'(ADDR_XFER)) sel = rf_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_last   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rf_we) rf_last <= rf_wdata;
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= sel;
    end
  end
endmodule

// File: rtl/dbg_ctl_port.sv
module dbg_ctl_port
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              dbg_rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              core_busy,
  input  logic              core_bkpt,
  input  logic              core_issue,
  input  logic              core_rf_we,
  input  logic [DATA_W-1:0] core_rf_wdata,
  output logic              core_halt,
  output logic              core_rst_req,
  output logic              inj_valid,
  output logic [DATA_W-1:0] inj_instr,
  input  logic              inj_ready
);
  logic              fire;
  logic              ctrl_wr;
  logic              xfer_wr;
  logic              rd_en;
  logic [DATA_W-1:0] ctrl_word;
  dbg_flags_t        flags;
  logic              step_flag;

  assign cmd_ready = !inj_valid;
  assign fire      = cmd_valid && cmd_ready;
  assign ctrl_wr   = fire && cmd_write && (cmd_addr == ADDR_W'(ADDR_CTRL));
  assign xfer_wr   = fire && cmd_write && (cmd_addr == ADDR_W'(ADDR_XFER));
  assign rd_en     = fire && !cmd_write;

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[RB_RST]  = flags.rst;
    ctrl_word[RB_HALT] = flags.halt;
    ctrl_word[RB_BUSY] = core_busy;
    ctrl_word[RB_BRK]  = flags.brk;
    ctrl_word[RB_STEP] = flags.step;
  end

  assign core_halt    = flags.halt;
  assign core_rst_req = flags.rst;
  assign step_flag    = flags.step;

  dbg_flags #(.DATA_W(DATA_W)) u_flags (
    .clk   (clk),
    .rst_n (dbg_rst_n),
    .wr_en (ctrl_wr),
    .wdata (cmd_wdata),
    .bkpt  (core_bkpt),
    .issue (core_issue),
    .flags (flags)
  );

  dbg_inject #(.DATA_W(DATA_W)) u_inject (
    .clk       (clk),
    .rst_n     (dbg_rst_n),
    .load      (xfer_wr),
    .ldata     (cmd_wdata),
    .inj_ready (inj_ready),
    .inj_valid (inj_valid),
    .inj_instr (inj_instr)
  );

  dbg_readback #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_readback (
    .clk       (clk),
    .rst_n     (dbg_rst_n),
    .rf_we     (core_rf_we),
    .rf_wdata  (core_rf_wdata),
    .rd_en     (rd_en),
    .rd_addr   (cmd_addr),
    .ctrl_word (ctrl_word),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/dbg_ctl_port_chk.sv
module dbg_ctl_port_chk
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              dbg_rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic              rsp_valid,
  input logic              core_bkpt,
  input logic              core_issue,
  input logic              core_halt,
  input logic              inj_valid,
  input logic              inj_ready,
  input logic [DATA_W-1:0] inj_instr,
  input logic              step_flag
);
  logic ctrl_wr_c;
  assign ctrl_wr_c = cmd_valid && cmd_ready && cmd_write
                     && (cmd_addr == ADDR_W'(ADDR_CTRL));

  // R2: read answered on the next cycle, write never answered
  a_r2_read_rsp: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    (cmd_valid && cmd_ready && !cmd_write) |=> rsp_valid);
  a_r2_write_silent: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    (cmd_valid && cmd_ready && cmd_write) |=> !rsp_valid);

  // R5: halt clear beats any set source in the same cycle
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    (ctrl_wr_c && cmd_wdata[WB_CLR_HALT]) |=> !core_halt);

  // R7: breakpoint halts unless cleared by the same-cycle write
  a_r7_bkpt_halts: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    (core_bkpt && !(ctrl_wr_c && cmd_wdata[WB_CLR_HALT])) |=> core_halt);

  // R8: a stepped issue re-halts the core
  a_r8_step_halts: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    (step_flag && !core_halt && core_issue
     && !(ctrl_wr_c && cmd_wdata[WB_CLR_HALT])) |=> core_halt);

  // R10: pending injection blocks commands and holds its word
  a_r10_ready_low: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    inj_valid |-> !cmd_ready);
  a_r10_hold: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    (inj_valid && !inj_ready) |=> (inj_valid && $stable(inj_instr)));
endmodule

bind dbg_ctl_port dbg_ctl_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .dbg_rst_n  (dbg_rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_write  (cmd_write),
  .cmd_addr   (cmd_addr),
  .cmd_wdata  (cmd_wdata),
  .rsp_valid  (rsp_valid),
  .core_bkpt  (core_bkpt),
  .core_issue (core_issue),
  .core_halt  (core_halt),
  .inj_valid  (inj_valid),
  .inj_ready  (inj_ready),
  .inj_instr  (inj_instr),
  .step_flag  (step_flag)
);

// File: tb/sim_dbg_ctl_port.sv
`timescale 1ns/1ps
module sim_dbg_ctl_port;
  logic        clk = 1'b0;
  logic        dbg_rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [7:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        core_busy = 1'b0;
  logic        core_bkpt = 1'b0;
  logic        core_issue = 1'b0;
  logic        core_rf_we = 1'b0;
  logic [31:0] core_rf_wdata = '0;
  logic        core_halt;
  logic        core_rst_req;
  logic        inj_valid;
  logic [31:0] inj_instr;
  logic        inj_ready = 1'b0;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dbg_ctl_port u0 (
    .clk(clk), .dbg_rst_n(dbg_rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .core_busy(core_busy), .core_bkpt(core_bkpt), .core_issue(core_issue),
    .core_rf_we(core_rf_we), .core_rf_wdata(core_rf_wdata),
    .core_halt(core_halt), .core_rst_req(core_rst_req),
    .inj_valid(inj_valid), .inj_instr(inj_instr), .inj_ready(inj_ready)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_exp(input logic r, input logic h,
      input logic b, input logic k, input logic s);
    return {27'd0, s, k, b, h, r};
  endfunction

  task automatic wait_ready();
    for (int i = 0; i < 50 && !cmd_ready; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wait_ready();
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
    wait_ready();
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    v = rsp_valid; d = rsp_data;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    dbg_rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({core_halt, core_rst_req, inj_valid, cmd_ready}, 32'b0001, "R1 outputs");
    rd(8'h00, d, v);
    chk(d, 32'd0, "R1 ctrl");
    rd(8'h04, d, v);
    chk(d, 32'd0, "R1 rf");

    // R2 response timing
    rd(8'h00, d, v);
    chk(v, 1, "R2 read valid");
    @(negedge clk);
    chk(rsp_valid, 0, "R2 single pulse");
    wr(8'h10, 32'h0);
    chk(rsp_valid, 0, "R2 write silent");

    // R3/R4/R5/R6/R11 sweep over set/clear/step bits from all start states
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 32; p++) begin
        logic er, eh;
        wr(8'h00, 32'h0300_0000);
        wr(8'h00, (32'(s & 1) << 16) | (32'((s >> 1) & 1) << 17));
        core_busy = p[0];
        wr(8'h00, (32'(p & 1) << 4) | (32'((p >> 1) & 1) << 16) |
                  (32'((p >> 2) & 1) << 17) | (32'((p >> 3) & 1) << 24) |
                  (32'((p >> 4) & 1) << 25));
        er = p[3] ? 1'b0 : (p[1] | s[0]);
        eh = p[4] ? 1'b0 : (p[2] | s[1]);
        chk({core_rst_req, core_halt}, {30'd0, er, eh}, "R11 pins");
        rd(8'h00, d, v);
        chk(d, ctrl_exp(er, eh, p[0], 1'b0, p[0]), "R3 R4 R5 R6 ctrl word");
      end
    end
    core_busy = 1'b0;
    wr(8'h00, 32'h0300_0000);

    // R7 breakpoint
    core_bkpt = 1'b1; @(negedge clk); core_bkpt = 1'b0;
    rd(8'h00, d, v);
    chk(d, ctrl_exp(0, 1, 0, 1, 0), "R7 bkpt");
    wr(8'h00, 32'h0200_0000);
    rd(8'h00, d, v);
    chk(d, 32'd0, "R5 clear brk");
    // R5 clear beats breakpoint in the same cycle
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 8'h00; cmd_wdata = 32'h0200_0000;
    core_bkpt = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0; core_bkpt = 1'b0;
    rd(8'h00, d, v);
    chk(d, 32'd0, "R5 clear beats bkpt");

    // R8 single step
    wr(8'h00, 32'h0000_0010);
    chk(core_halt, 0, "R8 released");
    core_issue = 1'b1; @(negedge clk); core_issue = 1'b0;
    chk(core_halt, 1, "R8 halt after step");
    rd(8'h00, d, v);
    chk(d, ctrl_exp(0, 1, 0, 0, 1), "R8 ctrl");
    wr(8'h00, 32'h0200_0000);
    core_issue = 1'b1; repeat (3) @(negedge clk); core_issue = 1'b0;
    chk(core_halt, 0, "R8 no step no halt");

    // R9 register file capture
    for (int k = 0; k < 4; k++) begin
      core_rf_we = 1'b1; core_rf_wdata = 32'h1000_0001 * (k + 3);
      @(negedge clk);
      core_rf_we = 1'b0; core_rf_wdata = 32'hDEAD_BEEF;
      @(negedge clk);
      rd(8'h04, d, v);
      chk(d, 32'h1000_0001 * (k + 3), "R9 last rf write");
    end

    // R10 injection
    wr(8'h04, 32'hCAFE_0013);
    chk({inj_valid, cmd_ready}, 32'b10, "R10 pending");
    chk(inj_instr, 32'hCAFE_0013, "R10 data");
    repeat (3) @(negedge clk);
    chk({inj_valid, cmd_ready}, 32'b10, "R10 held");
    chk(inj_instr, 32'hCAFE_0013, "R10 data held");
    inj_ready = 1'b1; @(negedge clk); inj_ready = 1'b0;
    chk({inj_valid, cmd_ready}, 32'b01, "R10 taken");

    // R12 unmapped addresses
    wr(8'h00, 32'h0001_0000);
    for (int a = 8; a < 256; a += 28) begin
      wr(8'(a), 32'h0301_0010);
      rd(8'(a), d, v);
      chk(d, 32'd0, "R12 unmapped read");
      chk(inj_valid, 0, "R12 no inject");
    end
    rd(8'h00, d, v);
    chk(d, ctrl_exp(1, 0, 0, 0, 0), "R12 flags untouched");

    summary();
  end
endmodule